// File: doc/BRIEF.md
# Switchable-Depth Receive Buffer

This block holds received bytes for a 16550-style serial controller between the line receiver and the host data-register read. It runs in one of two modes: a holding mode in which it keeps a single byte, and a queue mode in which it keeps up to `DEPTH` bytes (16 by default). The mode follows an enable bit carried by control-register writes. Any write that flips that bit empties the buffer, and the new capacity applies from the next cycle.

Bytes arrive on a push port. They come either from the line receiver or from the controller's internal loopback path, and a flag on the port says which. A push that finds the buffer at capacity is dropped. When the dropped byte came from loopback, the block emits a one-cycle overrun pulse for the line-status logic. The host pops the oldest byte with a data-register read. The head byte is shown combinationally on `pop_byte`, and an empty buffer shows 0xFF. A receiver-clear request empties the buffer, but only while queue mode is on. Status outputs give the occupancy count, a non-empty flag and a full flag.

Top module: `rxq_switch_fifo`

## Requirements
- R1: After reset, occupancy is 0, `not_empty`, `full` and `ovr_pulse` are 0, `pop_byte` reads 0xFF, and the buffer is in holding mode with a capacity of one.
- R2: In holding mode (last written enable bit = 0) the buffer stores exactly one byte. With one byte stored, `full` is 1, and a further push is dropped while the stored byte stays at the head.
- R3: In queue mode (last written enable bit = 1) the buffer stores up to `DEPTH` bytes and returns them oldest first. `full` is 0 with `DEPTH`-1 bytes stored.
- R4: A control write whose enable bit differs from the current mode empties the buffer and switches the capacity. A control write that repeats the current enable bit, with the clear bit at 0, leaves the contents untouched.
- R5: A control write with enable = 1 and clear = 1 in queue mode empties the buffer and keeps capacity `DEPTH`. The clear bit has no effect when the write carries enable = 0 in holding mode.
- R6: A push at capacity with no pop in the same cycle is dropped. If `push_lpbk` = 1 it drives `ovr_pulse` high for exactly the cycle after the dropped push. If `push_lpbk` = 0 no pulse is produced.
- R7: A pop on an empty buffer sees `pop_byte` = 0xFF and changes neither occupancy nor the order of later data.
- R8: A push and a pop in the same cycle on a non-empty buffer, full or not, leave occupancy unchanged and append the new byte behind the existing ones.
- R9: `occ` gives the number of stored bytes, `not_empty` is 1 exactly when `occ` is non-zero, and `full` is 1 exactly when `occ` equals the current capacity.
- R10: When a control write empties the buffer, a push or pop in the same cycle is discarded.
- R11: Read and write positions wrap modulo the current capacity, so data order survives many more transfers than `DEPTH`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_wr | input | 1 | Control-register write strobe |
| cfg_fifo_en | input | 1 | Enable bit of the control write (1 = queue mode) |
| cfg_rx_clr | input | 1 | Receiver-clear bit of the control write |
| push_vld | input | 1 | Push a byte this cycle |
| push_byte | input | DATA_W | Byte to push |
| push_lpbk | input | 1 | Pushed byte comes from the loopback path |
| pop_req | input | 1 | Host data-register read, pops the head |
| pop_byte | output | DATA_W | Head byte, or 0xFF when empty |
| occ | output | CNT_W | Occupancy count |
| not_empty | output | 1 | At least one byte stored |
| full | output | 1 | Occupancy equals current capacity |
| ovr_pulse | output | 1 | One-cycle overrun pulse after a dropped loopback push |

## Verification
The bench goes after the capacity edges in both modes. A design that ignored the mode would accept a second byte in holding mode, or raise `full` one entry early in queue mode. It writes the enable bit both to a new value and to the same value, and a design that flushed on every control write would lose queued data. It sends the clear bit with enable at 0, which a design that honored it would wrongly empty. It rejects pushes from both sources at capacity: a missing or stuck overrun shows up, as does a pulse raised for a line-side push. It issues paired push/pop at full, empty pops and long wrapping runs, and each of these would expose a miscounted or misordered index.

// File: rtl/rxq_pkg.sv
package rxq_pkg;

   typedef enum logic {
      MODE_HOLD  = 1'b0,
      MODE_QUEUE = 1'b1
   } rxq_mode_e;

endpackage

// File: rtl/rxq_mode_ctl.sv
module rxq_mode_ctl
   import rxq_pkg::*;
#(
   parameter int DEPTH = 16,
   localparam int IDX_W = $clog2(DEPTH),
   localparam int CNT_W = $clog2(DEPTH + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cfg_wr,
   input  logic             cfg_fifo_en,
   input  logic             cfg_rx_clr,
   output rxq_mode_e        mode,
   output logic             flush,
   output logic [IDX_W-1:0] cap_last,
   output logic [CNT_W-1:0] cap_cnt
);

   rxq_mode_e mode_q;
   rxq_mode_e wr_mode;
   logic      mode_flip;

   assign wr_mode   = cfg_fifo_en ? MODE_QUEUE : MODE_HOLD;
   assign mode_flip = cfg_wr && (wr_mode != mode_q);

   // flush on a mode flip, or on a clear request while the queue is enabled
   assign flush = mode_flip || (cfg_wr && cfg_fifo_en && cfg_rx_clr);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q <= MODE_HOLD;
      end else if (cfg_wr) begin
         mode_q <= wr_mode;
      end
   end

   assign mode     = mode_q;
   assign cap_last = (mode_q == MODE_QUEUE) ? IDX_W'(DEPTH - 1) : '0;
   assign cap_cnt  = (mode_q == MODE_QUEUE) ? CNT_W'(DEPTH) : CNT_W'(1);

endmodule

// File: rtl/rxq_index_ctl.sv
module rxq_index_ctl #(
   parameter int DEPTH = 16,
   localparam int IDX_W = $clog2(DEPTH),
   localparam int CNT_W = $clog2(DEPTH + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             flush,
   input  logic             push_vld,
   input  logic             push_lpbk,
   input  logic             pop_req,
   input  logic [IDX_W-1:0] cap_last,
   input  logic [CNT_W-1:0] cap_cnt,
   output logic [IDX_W-1:0] wr_idx,
   output logic [IDX_W-1:0] rd_idx,
   output logic [CNT_W-1:0] count,
   output logic             wr_en,
   output logic             ovr_pulse
);

   logic             at_cap;
   logic             is_empty;
   logic             do_pop;
   logic             do_push;
   logic             reject;
   logic [IDX_W-1:0] wr_nxt;
   logic [IDX_W-1:0] rd_nxt;
   logic             ovr_q;

   assign at_cap   = (count == cap_cnt);
   assign is_empty = (count == '0);
   assign do_pop   = pop_req && !is_empty && !flush;
   assign do_push  = push_vld && !flush && (!at_cap || do_pop);
   assign reject   = push_vld && !flush && at_cap && !do_pop;

   // wrap modulo the current capacity
   assign wr_nxt = (wr_idx == cap_last) ? '0 : wr_idx + 1'b1;
   assign rd_nxt = (rd_idx == cap_last) ? '0 : rd_idx + 1'b1;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_idx <= '0;
         rd_idx <= '0;
         count  <= '0;
         ovr_q  <= 1'b0;
      end else begin
         ovr_q <= reject && push_lpbk;
         if (flush) begin
            wr_idx <= '0;
            rd_idx <= '0;
            count  <= '0;
         end else begin
            if (do_push) begin
               wr_idx <= wr_nxt;
            end
            if (do_pop) begin
               rd_idx <= rd_nxt;
            end
            if (do_push && !do_pop) begin
               count <= count + 1'b1;
            end else if (do_pop && !do_push) begin
               count <= count - 1'b1;
            end
         end
      end
   end

   assign wr_en     = do_push;
   assign ovr_pulse = ovr_q;

endmodule

// File: rtl/rxq_store.sv
module rxq_store #(
   parameter int DATA_W = 8,
   parameter int DEPTH  = 16,
   localparam int IDX_W = $clog2(DEPTH)
) (
   input  logic              clk,
   input  logic              wr_en,
   input  logic [IDX_W-1:0]  wr_idx,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [IDX_W-1:0]  rd_idx,
   output logic [DATA_W-1:0] rd_data
);

   logic [DATA_W-1:0] ent [DEPTH];

   for (genvar e = 0; e < DEPTH; e++) begin : g_ent
      logic [DATA_W-1:0] cell_q;
      always_ff @(posedge clk) begin
         if (wr_en && (wr_idx == IDX_W'(e))) begin
            cell_q <= wr_data;
         end
      end
      assign ent[e] = cell_q;
   end

   assign rd_data = ent[rd_idx];

endmodule

// File: rtl/rxq_switch_fifo.sv
module rxq_switch_fifo
   import rxq_pkg::*;
#(
   parameter int DATA_W = 8,
   parameter int DEPTH  = 16,
   parameter logic [DATA_W-1:0] EMPTY_VAL = '1,
   localparam int IDX_W = $clog2(DEPTH),
   localparam int CNT_W = $clog2(DEPTH + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_wr,
   input  logic              cfg_fifo_en,
   input  logic              cfg_rx_clr,
   input  logic              push_vld,
   input  logic [DATA_W-1:0] push_byte,
   input  logic              push_lpbk,
   input  logic              pop_req,
   output logic [DATA_W-1:0] pop_byte,
   output logic [CNT_W-1:0]  occ,
   output logic              not_empty,
   output logic              full,
   output logic              ovr_pulse
);

   if (DEPTH < 2) begin : g_bad_depth
      $error("rxq_switch_fifo: DEPTH must be at least 2");
   end
   if (DATA_W < 1) begin : g_bad_width
      $error("rxq_switch_fifo: DATA_W must be at least 1");
   end

   rxq_mode_e         cur_mode;
   logic              flush_now;
   logic [IDX_W-1:0]  cap_last;
   logic [CNT_W-1:0]  cap_cnt;
   logic [IDX_W-1:0]  wr_idx;
   logic [IDX_W-1:0]  rd_idx;
   logic [CNT_W-1:0]  count;
   logic              wr_en;
   logic [DATA_W-1:0] head;

   rxq_mode_ctl #(.DEPTH(DEPTH)) u_mode (
      .clk         (clk),
      .rst_n       (rst_n),
      .cfg_wr      (cfg_wr),
      .cfg_fifo_en (cfg_fifo_en),
      .cfg_rx_clr  (cfg_rx_clr),
      .mode        (cur_mode),
      .flush       (flush_now),
      .cap_last    (cap_last),
      .cap_cnt     (cap_cnt)
   );

   rxq_index_ctl #(.DEPTH(DEPTH)) u_idx (
      .clk       (clk),
      .rst_n     (rst_n),
      .flush     (flush_now),
      .push_vld  (push_vld),
      .push_lpbk (push_lpbk),
      .pop_req   (pop_req),
      .cap_last  (cap_last),
      .cap_cnt   (cap_cnt),
      .wr_idx    (wr_idx),
      .rd_idx    (rd_idx),
      .count     (count),
      .wr_en     (wr_en),
      .ovr_pulse (ovr_pulse)
   );

   rxq_store #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_store (
      .clk     (clk),
      .wr_en   (wr_en),
      .wr_idx  (wr_idx),
      .wr_data (push_byte),
      .rd_idx  (rd_idx),
      .rd_data (head)
   );

   assign occ       = count;
   assign not_empty = (count != '0);
   assign full      = (count == cap_cnt);
   assign pop_byte  = not_empty ? head : EMPTY_VAL;

endmodule

// File: rtl/rxq_chk.sv
module rxq_chk
   import rxq_pkg::*;
#(
   parameter int DEPTH = 16,
   localparam int CNT_W = $clog2(DEPTH + 1)
) (
   input logic             clk,
   input logic             rst_n,
   input logic             cfg_wr,
   input logic             push_vld,
   input logic             push_lpbk,
   input logic             pop_req,
   input logic [CNT_W-1:0] occ,
   input logic             not_empty,
   input logic             full,
   input logic             ovr_pulse,
   input rxq_mode_e        cur_mode,
   input logic             flush_now
);

   // R2
   hold_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cur_mode == MODE_HOLD) |-> (occ <= CNT_W'(1)));

   // R3
   queue_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      occ <= CNT_W'(DEPTH));

   // R4
   flush_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
      flush_now |=> (occ == '0));

   // R6
   ovr_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ovr_pulse |-> $past(push_vld && push_lpbk && full && !pop_req));

   // R7
   empty_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pop_req && !not_empty && !push_vld && !cfg_wr) |=> (occ == '0));

   // R8
   pair_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (push_vld && pop_req && not_empty && !cfg_wr) |=> $stable(occ));

   // R9
   full_ne_chk: assert property (@(posedge clk) disable iff (!rst_n)
      full |-> not_empty);

endmodule

bind rxq_switch_fifo rxq_chk #(.DEPTH(DEPTH)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .cfg_wr    (cfg_wr),
   .push_vld  (push_vld),
   .push_lpbk (push_lpbk),
   .pop_req   (pop_req),
   .occ       (occ),
   .not_empty (not_empty),
   .full      (full),
   .ovr_pulse (ovr_pulse),
   .cur_mode  (cur_mode),
   .flush_now (flush_now)
);

// File: tb/sim_rxq_switch_fifo.sv
module sim_rxq_switch_fifo;

   localparam int CLK_P = 10;
   localparam int DEPTH = 16;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       cfg_wr = 1'b0, cfg_fifo_en = 1'b0, cfg_rx_clr = 1'b0;
   logic       push_vld = 1'b0, push_lpbk = 1'b0, pop_req = 1'b0;
   logic [7:0] push_byte = 8'h00;
   logic [7:0] pop_byte;
   logic [4:0] occ;
   logic       not_empty, full, ovr_pulse;

   int checks = 0;
   int errors = 0;
   logic [7:0] seen;

   always #(CLK_P/2) clk = ~clk;

   rxq_switch_fifo u0 (
      .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_fifo_en(cfg_fifo_en),
      .cfg_rx_clr(cfg_rx_clr), .push_vld(push_vld), .push_byte(push_byte),
      .push_lpbk(push_lpbk), .pop_req(pop_req), .pop_byte(pop_byte),
      .occ(occ), .not_empty(not_empty), .full(full), .ovr_pulse(ovr_pulse)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic chk_eq(input string req, input int act, input int exp);
      chk(act == exp, req, act, exp);
   endtask

   // one cycle: drive at negedge, capture head, let the edge act, release
   task automatic cyc(input bit pv, input logic [7:0] pb, input bit lp, input bit pr,
                      input bit wr, input bit en, input bit clr);
      @(negedge clk);
      push_vld = pv; push_byte = pb; push_lpbk = lp; pop_req = pr;
      cfg_wr = wr; cfg_fifo_en = en; cfg_rx_clr = clr;
      #1 seen = pop_byte;
      @(posedge clk);
      #1;
      push_vld = 0; pop_req = 0; cfg_wr = 0; cfg_rx_clr = 0; push_lpbk = 0;
   endtask

   task automatic push(input logic [7:0] b);
      cyc(1, b, 0, 0, 0, 0, 0);
   endtask

   task automatic pop_exp(input string req, input logic [7:0] b);
      cyc(0, 8'h00, 0, 1, 0, 0, 0);
      chk_eq(req, seen, b);
   endtask

   task automatic t_reset;
      chk_eq("R1 occ", occ, 0);
      chk_eq("R1 not_empty", not_empty, 0);
      chk_eq("R1 full", full, 0);
      chk_eq("R1 ovr", ovr_pulse, 0);
      chk_eq("R1 pop_byte", pop_byte, 8'hFF);
   endtask

   task automatic t_hold;
      push(8'hA5);
      chk_eq("R1 R2 occ after one push", occ, 1);
      chk_eq("R2 R9 full with one byte", full, 1);
      push(8'h3C);
      chk_eq("R2 occ after rejected push", occ, 1);
      chk_eq("R6 no pulse for line push", ovr_pulse, 0);
      cyc(1, 8'h77, 1, 0, 0, 0, 0);
      chk_eq("R6 pulse after loopback reject", ovr_pulse, 1);
      cyc(0, 8'h00, 0, 0, 0, 0, 0);
      chk_eq("R6 pulse lasts one cycle", ovr_pulse, 0);
      pop_exp("R2 head kept", 8'hA5);
      chk_eq("R2 occ after pop", occ, 0);
      // paired push/pop while full in holding mode
      push(8'h41);
      cyc(1, 8'h42, 0, 1, 0, 0, 0);
      chk_eq("R8 hold pair head", seen, 8'h41);
      chk_eq("R8 hold pair occ", occ, 1);
      pop_exp("R8 hold pair new byte", 8'h42);
   endtask

   task automatic t_empty;
      cyc(0, 8'h00, 0, 1, 0, 0, 0);
      chk_eq("R7 empty pop reads FF", seen, 8'hFF);
      chk_eq("R7 occ stays 0", occ, 0);
      chk_eq("R7 not_empty stays 0", not_empty, 0);
      push(8'h11);
      pop_exp("R7 order intact after empty pop", 8'h11);
   endtask

   task automatic t_mode;
      push(8'h22);
      cyc(0, 8'h00, 0, 0, 1, 1, 0);
      chk_eq("R4 enable flip empties", occ, 0);
      push(8'h01); push(8'h02);
      chk_eq("R4 queue holds two", occ, 2);
      cyc(0, 8'h00, 0, 0, 1, 1, 0);
      chk_eq("R4 same-value write keeps data", occ, 2);
      pop_exp("R4 data intact 1", 8'h01);
      pop_exp("R4 data intact 2", 8'h02);
   endtask

   task automatic t_queue;
      for (int i = 0; i < DEPTH - 1; i++) push(8'(i * 7 + 1));
      chk_eq("R3 not full at DEPTH-1", full, 0);
      push(8'(15 * 7 + 1));
      chk_eq("R3 occ at DEPTH", occ, DEPTH);
      chk_eq("R3 R9 full at DEPTH", full, 1);
      cyc(1, 8'hEE, 1, 0, 0, 0, 0);
      chk_eq("R6 queue overrun pulse", ovr_pulse, 1);
      chk_eq("R6 occ unchanged", occ, DEPTH);
      // paired push/pop at full
      cyc(1, 8'hC0, 0, 1, 0, 0, 0);
      chk_eq("R8 pair head", seen, 8'h01);
      chk_eq("R8 pair occ kept", occ, DEPTH);
      for (int i = 1; i < DEPTH; i++) pop_exp("R3 order", 8'(i * 7 + 1));
      pop_exp("R8 appended byte", 8'hC0);
      chk_eq("R9 empty at end", not_empty, 0);
   endtask

   task automatic t_wrap;
      push(8'h90); push(8'h91); push(8'h92);
      for (int i = 0; i < 40; i++) begin
         cyc(1, 8'(8'h93 + i), 0, 1, 0, 0, 0);
         chk_eq("R11 wrap order", seen, 8'(8'h90 + i));
      end
      chk_eq("R11 occ after wrap", occ, 3);
   endtask

   task automatic t_clr;
      cyc(0, 8'h00, 0, 0, 1, 1, 1);
      chk_eq("R5 clear empties queue", occ, 0);
      for (int i = 0; i < DEPTH + 1; i++) push(8'(i));
      chk_eq("R5 capacity kept after clear", occ, DEPTH);
      cyc(0, 8'h00, 0, 0, 1, 0, 0);
      chk_eq("R4 disable flip empties", occ, 0);
      push(8'h5A); push(8'h5B);
      chk_eq("R4 holding capacity one", occ, 1);
      cyc(0, 8'h00, 0, 0, 1, 0, 1);
      chk_eq("R5 clear ignored in holding", occ, 1);
      chk_eq("R5 head intact", pop_byte, 8'h5A);
      pop_exp("R5 data after ignored clear", 8'h5A);
   endtask

   task automatic t_flush_prio;
      cyc(1, 8'h66, 0, 0, 1, 1, 0);
      chk_eq("R10 push discarded on flush", occ, 0);
      push(8'h67);
      cyc(1, 8'h68, 0, 1, 1, 0, 0);
      chk_eq("R10 push/pop discarded on flush", occ, 0);
      chk_eq("R10 pop_byte empty", pop_byte, 8'hFF);
   endtask

   initial begin
      #(CLK_P * 100000);
      errors++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      #(CLK_P * 3);
      @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_hold();
      t_empty();
      t_mode();
      t_queue();
      t_wrap();
      t_clr();
      t_flush_prio();
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule